// File: doc/BRIEF.md
# Latched-Address Static RAM Cycle Controller

This block turns single host requests into complete strobe sequences for a 2K x 8 static RAM. That RAM captures its address inside the chip on the falling edge of its active-low chip enable. The host offers a request on a valid/ready handshake: an address, write data and a write flag. The controller then drives the address bus, the enable, output-enable and write strobes, and the data bus with its drive-enable. When the access ends it returns a one-cycle done pulse. For reads, the captured byte appears on the read-data output at the same time.

Every interval in the access is a parameter given as a whole number of system clocks. This covers address setup and hold around the enable fall, read access time, write pulse width, data hold, minimum enable-low width and enable-high precharge. Because the RAM holds the address internally, the controller returns the address bus to zero once the hold interval after the enable fall has passed. The sequence runs through nine states. In IDLE, a request with valid high moves to SETUP. SETUP moves to HOLD when the setup count ends. HOLD moves to WDRIVE for a write, or to RACC for a read. WDRIVE moves to WPULSE after one cycle, and WPULSE moves to WHOLD when the pulse count ends. Both WHOLD and RACC move to ENDE when their count ends. ENDE moves to PRECH once the minimum enable-low width has elapsed. PRECH moves back to IDLE when the precharge count ends.

Top module: `lsram_cycle_ctrl`

## Requirements
- R1: During and right after reset the outputs are in these states. The enable, output-enable and write outputs are high (1 = inactive). The data drive-enable is 0, the address bus is 0, ready is 1 and done is 0.
- R2: Ready is 1 only in IDLE. A request is taken on a cycle where valid and ready are both 1. Valid, address, data and flag values presented at any other time have no effect on the bus.
- R3: The address is driven for exactly T_ASU cycles with the enable high. The enable then falls, and the address keeps the same value on the cycle of the fall.
- R4: The address stays driven for T_AHD cycles with the enable low, counting the fall cycle. After that the address bus returns to 0 until the next access.
- R5: In a read, the write strobe stays high for the whole access. Output-enable is low for exactly T_ACC cycles right after the hold interval. The byte present on the last of those cycles is what gets returned.
- R6: In a write, the data is driven for one cycle before the write strobe falls. The write strobe is then low for T_WPW cycles. Data stays driven and unchanged for T_DHD cycles after the strobe rises, and drive-enable is 0 at all other times.
- R7: The data bus is never driven while output-enable is low, and output-enable is low only while the enable is low.
- R8: The enable is low for at least T_EPW cycles. The last low cycle always has output-enable and write high.
- R9: The enable stays high for T_PRE cycles after an access before ready returns. Done is 1 for exactly the first of those cycles. For a read, the read-data output then holds the byte stored at the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_e_n | output | 1 | RAM chip enable, active low, address taken on its fall |
| mem_g_n | output | 1 | RAM output enable, active low |
| mem_w_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | 11 | RAM address bus |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for the data bus tristate |
| mem_dq_in | input | 8 | Data read from the RAM |

## Verification
The assertions assume that mem_dq_in carries a valid byte by the last cycle of the output-enable window. They also assume that every timing parameter is at least 1. A width that matches the enable-low span is only checked if T_EPW fits in the counter width derived from the largest parameter. The bench memory model turns stale outputs into a fixed garbage byte until output-enable has been low for T_ACC cycles, so any early sample shows up as a data error. Host inputs change only just after a rising edge. Requests are deliberately held or scrambled while the controller is busy, so the handshake is the only way a request can start.

// File: rtl/lsram_pkg.sv
`timescale 1ns/1ps
package lsram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_WDRIVE,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_ENDE,
        ST_PRECH
    } lsram_state_e;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsram_interval_timer.sv
`timescale 1ns/1ps
// Loadable down-counter; expired is high when the count sits at zero.
module lsram_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lsram_req_hold.sv
`timescale 1ns/1ps
// Captures one accepted host request for the duration of the access.
module lsram_req_hold #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              held_write,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_write <= 1'b0;
            held_addr  <= '0;
            held_data  <= '0;
        end else if (take) begin
            held_write <= in_write;
            held_addr  <= in_addr;
            held_data  <= in_data;
        end
    end

endmodule

// File: rtl/lsram_cycle_ctrl.sv
`timescale 1ns/1ps
module lsram_cycle_ctrl
    import lsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int T_ASU  = 2,   // address setup before enable fall
    parameter int T_AHD  = 1,   // address hold after enable fall
    parameter int T_ACC  = 3,   // output-enable low window for reads
    parameter int T_WPW  = 2,   // write strobe low width
    parameter int T_DHD  = 1,   // data hold after write strobe rise
    parameter int T_EPW  = 6,   // minimum enable-low width
    parameter int T_PRE  = 3    // enable-high precharge
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_e_n,
    output logic              mem_g_n,
    output logic              mem_w_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int T_MAX = max_of2(max_of2(max_of2(T_ASU, T_AHD), max_of2(T_ACC, T_WPW)),
                                   max_of2(max_of2(T_DHD, T_EPW), T_PRE));
    localparam int CNT_W = $clog2(T_MAX + 1);

    lsram_state_e     state_q, state_d;
    logic             take;
    logic             held_write;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_data;
    logic             ph_load, ph_done;
    logic [CNT_W-1:0] ph_val;
    logic             ew_load, ew_done;

    assign take = req_valid && req_ready;

    lsram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .take(take),
        .in_write(req_write), .in_addr(req_addr), .in_data(req_wdata),
        .held_write(held_write), .held_addr(held_addr), .held_data(held_data)
    );

    // Phase timer: reloaded on every state change with the new state's length minus one.
    lsram_interval_timer #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done)
    );

    // Enable-width timer: started as the enable falls, consulted in ENDE.
    lsram_interval_timer #(.CNT_W(CNT_W)) u_ewidth (
        .clk(clk), .rst_n(rst_n), .load(ew_load),
        .load_val(CNT_W'(T_EPW - 1)), .expired(ew_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_SETUP;
            ST_SETUP:  if (ph_done)    state_d = ST_HOLD;
            ST_HOLD:   if (ph_done)    state_d = held_write ? ST_WDRIVE : ST_RACC;
            ST_WDRIVE:                 state_d = ST_WPULSE;
            ST_WPULSE: if (ph_done)    state_d = ST_WHOLD;
            ST_WHOLD:  if (ph_done)    state_d = ST_ENDE;
            ST_RACC:   if (ph_done)    state_d = ST_ENDE;
            ST_ENDE:   if (ew_done)    state_d = ST_PRECH;
            ST_PRECH:  if (ph_done)    state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ph_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:  ph_val = CNT_W'(T_ASU - 1);
            ST_HOLD:   ph_val = CNT_W'(T_AHD - 1);
            ST_WPULSE: ph_val = CNT_W'(T_WPW - 1);
            ST_WHOLD:  ph_val = CNT_W'(T_DHD - 1);
            ST_RACC:   ph_val = CNT_W'(T_ACC - 1);
            ST_PRECH:  ph_val = CNT_W'(T_PRE - 1);
            default:   ph_val = '0;
        endcase
    end

    assign ew_load = (state_q == ST_SETUP) && (state_d == ST_HOLD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pin decode
    always_comb begin
        req_ready  = 1'b0;
        mem_e_n    = 1'b1;
        mem_g_n    = 1'b1;
        mem_w_n    = 1'b1;
        mem_addr   = '0;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SETUP:  mem_addr  = held_addr;
            ST_HOLD:   begin mem_e_n = 1'b0; mem_addr = held_addr; end
            ST_WDRIVE: begin mem_e_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WPULSE: begin mem_e_n = 1'b0; mem_dq_oe = 1'b1; mem_w_n = 1'b0; end
            ST_WHOLD:  begin mem_e_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_RACC:   begin mem_e_n = 1'b0; mem_g_n = 1'b0; end
            ST_ENDE:   mem_e_n = 1'b0;
            ST_PRECH:  ;
            default:   ;
        endcase
        mem_dq_out = mem_dq_oe ? held_data : '0;
    end

    // Response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            if (state_q == ST_RACC && ph_done) rsp_rdata <= mem_dq_in;
            rsp_done <= (state_q == ST_ENDE) && ew_done;
        end
    end

    // Enable-low span, measured at the pins for the width check
    logic [CNT_W:0] elow_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           elow_len <= '0;
        else if (mem_e_n)                     elow_len <= '0;
        else if (elow_len < (CNT_W+1)'(T_EPW)) elow_len <= elow_len + 1'b1;
    end

    AST_E_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_e_n) |-> elow_len >= (CNT_W+1)'(T_EPW)); // R8
    AST_ADDR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_e_n) |-> mem_addr == $past(mem_addr)); // R3
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_g_n); // R7
    AST_G_NEEDS_E: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_g_n |-> (!mem_e_n && mem_w_n)); // R5
    AST_W_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_w_n |-> (mem_dq_oe && !mem_e_n && $past(mem_dq_oe))); // R6
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_e_n && !mem_dq_oe && !rsp_done)); // R2
    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $rose(mem_e_n)); // R9

endmodule

// File: tb/lsram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module lsram_cycle_ctrl_test;
    localparam int T_ASU = 2, T_AHD = 1, T_ACC = 3, T_WPW = 2;
    localparam int T_DHD = 1, T_EPW = 6, T_PRE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, mem_e_n, mem_g_n, mem_w_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
    logic [10:0] mem_addr;

    int checks = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;

    lsram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_e_n(mem_e_n),
        .mem_g_n(mem_g_n), .mem_w_n(mem_w_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural RAM with timing monitors ----------------
    logic [7:0]  mmem [2048];
    logic [7:0]  refm [2048];
    logic [10:0] lat = '0, pa = '0;
    logic [7:0]  pdq = '0, wd = '0;
    logic        pe = 1'b1, pw = 1'b1, poe = 1'b0;
    int ehi = 100, elo = 0, same = 0, wlo = 0, dqrun = 0, hold_left = 0, dh_left = 0, gl = 0;

    assign mem_dq_in = (gl >= T_ACC) ? mmem[lat] : 8'hEE;

    always @(negedge clk) if (rst_n) begin
        if (!mem_g_n && mem_dq_oe) chk(0, "R7", "bus driven with G low", 1, 0);
        if (pe && !mem_e_n) begin
            chk(ehi >= T_PRE, "R9", "enable-high time before fall", ehi, T_PRE);
            chk(same >= T_ASU && mem_addr == pa, "R3", "address setup run", same, T_ASU);
            lat = mem_addr;
            hold_left = T_AHD;
        end
        if (!pe && mem_e_n) chk(elo >= T_EPW, "R8", "enable-low width", elo, T_EPW);
        if (!mem_e_n && hold_left > 0) begin
            chk(mem_addr == lat, "R4", "address hold", int'(mem_addr), int'(lat));
            hold_left--;
        end
        if (!pw && mem_w_n) begin
            chk(wlo >= T_WPW, "R6", "write pulse width", wlo, T_WPW);
            chk(dqrun >= T_WPW + 1, "R6", "data setup run", dqrun, T_WPW + 1);
            mmem[lat] = pdq;
            wd = pdq;
            dh_left = T_DHD;
        end
        if (dh_left > 0) begin
            chk(mem_dq_oe && mem_dq_out == wd, "R6", "data hold", int'(mem_dq_out), int'(wd));
            dh_left--;
        end
        ehi   = mem_e_n ? (pe ? ehi + 1 : 1) : 0;
        elo   = !mem_e_n ? (!pe ? elo + 1 : 1) : 0;
        same  = (mem_addr == pa) ? same + 1 : 1;
        wlo   = !mem_w_n ? (!pw ? wlo + 1 : 1) : 0;
        dqrun = mem_dq_oe ? ((poe && mem_dq_out == pdq) ? dqrun + 1 : 1) : 0;
        gl    = (!mem_e_n && !mem_g_n) ? gl + 1 : 0;
        pe = mem_e_n; pw = mem_w_n; pa = mem_addr; pdq = mem_dq_out; poe = mem_dq_oe;
    end

    // ---------------- cycle-by-cycle reference trace ----------------
    typedef struct {
        bit e, g, w, oe, rdy, done, rdchk;
        logic [10:0] a;
        logic [7:0]  d;
    } exp_t;
    exp_t q[$];

    function automatic exp_t idle_pins();
        exp_t x;
        x.e = 1; x.g = 1; x.w = 1; x.oe = 0; x.rdy = 1; x.done = 0; x.rdchk = 0;
        x.a = '0; x.d = '0;
        return x;
    endfunction

    task automatic push_access(input bit wr, input logic [10:0] a, input logic [7:0] d);
        exp_t x = idle_pins();
        int low;
        x.rdy = 0;
        x.a = a;
        repeat (T_ASU) q.push_back(x);              // R3 setup
        x.e = 0;
        repeat (T_AHD) q.push_back(x);              // R4 hold
        x.a = '0;
        if (wr) begin
            x.oe = 1; x.d = d; q.push_back(x);      // R6 drive ahead of strobe
            x.w = 0; repeat (T_WPW) q.push_back(x);
            x.w = 1; repeat (T_DHD) q.push_back(x);
            x.oe = 0;
            low = T_AHD + 1 + T_WPW + T_DHD;
            refm[a] = d;
        end else begin
            x.g = 0; repeat (T_ACC) q.push_back(x); // R5 read window
            x.g = 1;
            low = T_AHD + T_ACC;
            x.d = refm[a];
        end
        repeat ((T_EPW - low > 1) ? T_EPW - low : 1) q.push_back(x);  // R8
        x.e = 1; x.done = 1; x.rdchk = !wr; q.push_back(x);          // R9
        x.done = 0; x.rdchk = 0;
        repeat (T_PRE - 1) q.push_back(x);
    endtask

    always @(negedge clk) if (rst_n) begin
        exp_t x;
        cyc++;
        x = (q.size() > 0) ? q.pop_front() : idle_pins();
        chk(mem_e_n == x.e, "R8", "enable pin", mem_e_n, x.e);
        chk(mem_g_n == x.g, "R5", "output-enable pin", mem_g_n, x.g);
        chk(mem_w_n == x.w, "R6", "write pin", mem_w_n, x.w);
        chk(mem_dq_oe == x.oe, "R6", "drive-enable", mem_dq_oe, x.oe);
        chk(req_ready == x.rdy, "R2", "ready", req_ready, x.rdy);
        chk(rsp_done == x.done, "R9", "done", rsp_done, x.done);
        chk(mem_addr == x.a, "R4", "address bus", int'(mem_addr), int'(x.a));
        if (x.oe) chk(mem_dq_out == x.d, "R6", "write data", int'(mem_dq_out), int'(x.d));
        if (x.rdchk) chk(rsp_rdata == x.d, "R9", "read data", int'(rsp_rdata), int'(x.d));
        if (req_valid && req_ready) push_access(req_write, req_addr, req_wdata);
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d, input bit keep);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        if (!keep) req_valid = 0;
        // R2: scramble inputs while busy; they must not reach the bus
        req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    endtask

    task automatic drain();
        do @(negedge clk); while (q.size() > 0);
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mmem[i] = 8'(i) ^ 8'h5A;
            refm[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_e_n && mem_g_n && mem_w_n, "R1", "strobes in reset", {mem_e_n, mem_g_n, mem_w_n}, 7);
        chk(!mem_dq_oe && mem_addr == 0, "R1", "bus in reset", int'(mem_addr), 0);
        chk(req_ready && !rsp_done, "R1", "handshake in reset", {req_ready, rsp_done}, 2);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(req_ready && mem_e_n && mem_addr == 0, "R1", "first cycle after reset", req_ready, 1);

        issue(1, 11'h000, 8'hA5, 0); drain();       // R6 write
        issue(1, 11'h7FF, 8'h3C, 0); drain();
        issue(0, 11'h7FF, 8'h00, 0); drain();       // R5 read back
        issue(0, 11'h000, 8'h00, 0); drain();
        issue(0, 11'h123, 8'h00, 0); drain();       // preset content
        // back-to-back with valid held across the busy period (R2, R9 precharge)
        issue(1, 11'h123, 8'hFF, 1);
        issue(0, 11'h123, 8'h00, 1);
        issue(1, 11'h456, 8'h00, 1);
        issue(0, 11'h456, 8'h00, 0);
        drain();
        issue(0, 11'h2AA, 8'h00, 0); drain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule